// File: doc/BRIEF.md
# Dual-Mode Feedback Conversion Sequencer

This block is the digital control core of a feedback analog-to-digital converter. It drives an n-bit trial code to an external DAC and reads back one comparator bit, which is high when the analog input is at or above the DAC output. From that bit it works out the digital value of the input. The comparator and the DAC sit outside the block.

Two algorithms share one interface, and a mode input picks between them when a conversion starts. The counting ramp steps the code upward from zero until the comparator drops. Its latency grows with the input level. The binary search decides one bit per cycle, starting at the most significant bit, so its latency is fixed. A one-cycle start pulse begins a conversion. A one-cycle done pulse marks the cycle in which the final code appears on the result output, and the result then holds until the next accepted start.

Top module: `seqTop`

## Requirements
- R1: After reset, busy and done are low and both dacCode and result are zero.
- R2: When start is accepted with modeSar=0 (counting mode), dacCode is 0 in the first busy cycle. While the comparator is high and the code is below all ones, dacCode increases by exactly one on each clock.
- R3: In counting mode, the first cycle with the comparator low ends the conversion. The result is the last code for which the comparator was high, which is the input level. With the start captured at edge 0, done is high after edge level+2.
- R4: In counting mode, an input at or above full scale makes the code stop at all ones without wrapping. The result is then all ones, and done is high after edge 2^WIDTH.
- R5: When start is accepted with modeSar=1 (binary search), the first trial code has only the MSB set. Each later step keeps the current trial bit if the comparator is high and clears it otherwise, then sets the next lower bit.
- R6: A binary search takes exactly WIDTH trial steps. Done is high after edge WIDTH, and the result equals the input level, saturated at all ones.
- R7: An accepted start clears result to zero. Result stays zero and busy stays high until the conversion ends.
- R8: Done is a single-cycle pulse. It comes with the result update and with busy going low.
- R9: A start pulse that arrives while busy is high is ignored. The running conversion keeps its mode, its result and its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a conversion |
| modeSar | input | 1 | Algorithm select, sampled at start: 1 = binary search, 0 = counting ramp |
| cmpHigh | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| dacCode | output | WIDTH | Trial code driven to the DAC |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle pulse when the final result is latched |
| result | output | WIDTH | Converted value, held between conversions |

## Verification
The assertions assume the comparator is an ideal, memoryless threshold. Its bit must reflect the dacCode of the same cycle, and the analog level must stay constant for the whole conversion. The bench meets this by deriving cmpHigh combinationally from a fixed integer level compared against dacCode. That level changes only while the block is idle. The assertions also assume start is a single-cycle pulse. The bench drives every start, including the one it injects during a conversion, for exactly one clock.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_SAR   = 2'd2
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic initCount;   // code <= 0, result <= 0
    logic initSar;     // code <= MSB only, result <= 0
    logic countUp;     // code <= code + 1
    logic sarTrial;    // decide current bit, set next lower bit
    logic latchCount;  // end of ramp, capture result
    logic latchSar;    // last bit decided, capture result
  } seqStrobe_t;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeSar,
  input  logic             cmpHigh,
  input  logic             codeFull,
  output seqStrobe_t       strobe,
  output logic [WIDTH-1:0] trialMask,
  output logic             busy,
  output logic             done
);

  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  seqState_t     state, stateNext;
  logic [IDXW-1:0] bitIdx, bitIdxNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    bitIdxNext = bitIdx;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (modeSar) begin
            strobe.initSar = 1'b1;
            bitIdxNext     = TOP_IDX;
            stateNext      = ST_SAR;
          end else begin
            strobe.initCount = 1'b1;
            stateNext        = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (cmpHigh && !codeFull) begin
          strobe.countUp = 1'b1;
        end else begin
          strobe.latchCount = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      ST_SAR: begin
        if (bitIdx == '0) begin
          strobe.latchSar = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobe.sarTrial = 1'b1;
          bitIdxNext      = bitIdx - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      state  <= stateNext;
      bitIdx <= bitIdxNext;
      done   <= strobe.latchCount | strobe.latchSar;
    end
  end

  assign trialMask = WIDTH'(1) << bitIdx;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [WIDTH-1:0] trialMask,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result,
  output logic             codeFull
);

  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] decided;

  // Current code with the trial bit resolved by the comparator
  assign decided  = cmpHigh ? code : (code & ~trialMask);
  assign codeFull = &code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code   <= '0;
      result <= '0;
    end else begin
      if (strobe.initCount) begin
        code   <= '0;
        result <= '0;
      end
      if (strobe.initSar) begin
        code   <= MSB_ONLY;
        result <= '0;
      end
      if (strobe.countUp)
        code <= code + 1'b1;
      if (strobe.sarTrial)
        code <= decided | (trialMask >> 1);
      if (strobe.latchCount)
        result <= cmpHigh ? code : code - 1'b1;
      if (strobe.latchSar)
        result <= decided;
    end
  end

endmodule

// File: rtl/seqTop.sv
module seqTop
  import seqPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeSar,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  seqStrobe_t       strobe;
  logic [WIDTH-1:0] trialMask;
  logic             codeFull;

  seqCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeSar   (modeSar),
    .cmpHigh   (cmpHigh),
    .codeFull  (codeFull),
    .strobe    (strobe),
    .trialMask (trialMask),
    .busy      (busy),
    .done      (done)
  );

  seqDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .trialMask (trialMask),
    .cmpHigh   (cmpHigh),
    .code      (dacCode),
    .result    (result),
    .codeFull  (codeFull)
  );

endmodule

// File: rtl/seqTopChecker.sv
module seqTopChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             modeSar,
  input logic             cmpHigh,
  input logic [WIDTH-1:0] dacCode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  localparam int CW = $clog2(WIDTH + 2) + 1;

  logic          sarRun;    // mode of the accepted conversion
  logic [CW-1:0] busyCnt;   // busy cycles since the accepted start
  logic          seenStart; // a start has been accepted since reset

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarRun    <= 1'b0;
      busyCnt   <= '0;
      seenStart <= 1'b0;
    end else if (start && !busy) begin
      sarRun    <= modeSar;
      busyCnt   <= '0;
      seenStart <= 1'b1;
    end else if (busy && busyCnt != '1) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  // R2: ramp advances by one while the comparator is high and the code is below full scale
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    busy && !sarRun && cmpHigh && (dacCode != '1) |=> busy && (dacCode == $past(dacCode) + 1'b1));

  // R4: the ramp never goes down, so it cannot wrap
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !sarRun |-> dacCode >= $past(dacCode));

  // R6: binary search finishes after exactly WIDTH busy cycles
  a_r6_sar_len: assert property (@(posedge clk) disable iff (!rstN)
    done && sarRun && seenStart |-> busyCnt == CW'(WIDTH));

  // R7: result cleared while a conversion runs
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> result == '0);

  // R8: done lasts one cycle and only when idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy ##1 !done);

  // R9: a start while busy does not restart the conversion
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !sarRun && cmpHigh && (dacCode != '1) |=> dacCode != '0);

endmodule

bind seqTop seqTopChecker #(.WIDTH(WIDTH)) u_seqTopChecker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .modeSar (modeSar),
  .cmpHigh (cmpHigh),
  .dacCode (dacCode),
  .busy    (busy),
  .done    (done),
  .result  (result)
);

// File: tb/test_seqTop.sv
module test_seqTop;

  localparam int WIDTH = 8;
  localparam int FULL  = (1 << WIDTH) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             modeSar = 1'b0;
  logic [WIDTH-1:0] dacCode;
  logic             busy, done;
  logic [WIDTH-1:0] result;
  int               level = 0;
  logic             cmpHigh;

  int checks = 0;
  int errors = 0;

  // Ideal comparator against the stimulus level
  assign cmpHigh = (level >= int'(dacCode));

  always #5 clk = ~clk;

  seqTop #(.WIDTH(WIDTH)) i_seqTop (
    .clk(clk), .rstN(rstN), .start(start), .modeSar(modeSar), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // One conversion; injectAt >= 0 pulses an extra start (opposite mode) at that cycle
  task automatic runConv(input logic sar, input int lvl, input int injectAt, input string tag);
    int expRes, expLat, n;
    bit seen;
    expRes = (lvl > FULL) ? FULL : lvl;
    if (sar) expLat = WIDTH;
    else     expLat = (lvl >= FULL) ? FULL + 1 : lvl + 2;
    level = lvl;
    @(negedge clk);
    start = 1'b1; modeSar = sar;
    @(negedge clk);
    start = 1'b0; modeSar = 1'b0;
    // after edge 0
    check({tag, " R7 busy"}, int'(busy), 1);
    check({tag, " R7 cleared"}, int'(result), 0);
    if (sar) check({tag, " R5 first trial"}, int'(dacCode), 1 << (WIDTH - 1));
    else     check({tag, " R2 ramp start"}, int'(dacCode), 0);
    n = 0;
    seen = 0;
    while (n < 600 && !seen) begin
      if (n == injectAt) begin
        start = 1'b1; modeSar = ~sar;
      end
      @(negedge clk);
      start = 1'b0; modeSar = 1'b0;
      n++;
      if (n == 1 && !done) begin
        if (sar) check({tag, " R5 second trial"}, int'(dacCode),
                       ((lvl >= (1 << (WIDTH - 1))) ? (1 << (WIDTH - 1)) : 0) | (1 << (WIDTH - 2)));
        else     check({tag, " R2 ramp step"}, int'(dacCode), 1);
      end
      if (done) seen = 1;
    end
    check({tag, sar ? " R6 latency" : " R3/R4 latency"}, n, expLat);
    check({tag, sar ? " R6 result" : " R3/R4 result"}, int'(result), expRes);
    check({tag, " R8 busy low at done"}, int'(busy), 0);
    @(negedge clk);
    check({tag, " R8 done single pulse"}, int'(done), 0);
    check({tag, " R8 result held"}, int'(result), expRes);
  endtask

  task automatic testReset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 dacCode", int'(dacCode), 0);
    check("R1 result", int'(result), 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runConv(1'b0, 37,  -1, "count mid");
    runConv(1'b0, 0,   -1, "count zero");
    runConv(1'b0, 254, -1, "count near top");
    runConv(1'b0, 255, -1, "count R4 full");
    runConv(1'b0, 300, -1, "count R4 over");
    runConv(1'b1, 37,  -1, "sar mid");
    runConv(1'b1, 0,   -1, "sar zero");
    runConv(1'b1, 200, -1, "sar high");
    runConv(1'b1, 255, -1, "sar full");
    runConv(1'b1, 128, -1, "sar msb edge");
    runConv(1'b0, 50,  5,  "count R9 inject");
    runConv(1'b1, 90,  3,  "sar R9 inject");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule